// File: doc/BRIEF.md
# Command-Decoding Write-Only I2C Slave

This block is the receive side of a two-wire control port for a switch-matrix controller. It watches SCL and SDA through the system clock, finds START and STOP conditions, and takes in a frame made of an address byte, a command byte and then the payload. The command byte chooses the payload length. When bit 6 of the command is set, the payload is a 16-bit word sent high byte first. For any other command the payload is a single byte.

The slave pulls SDA low for one SCL period after each byte it accepts. When the last payload byte of a frame has been acknowledged, it presents the command and the payload to the register bank with a one-cycle commit strobe. Two strap inputs set the low address bits, so four of these slaves can share one bus. The block does not support reads, clock stretching or general call.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After reset, sda_pull and commit are low and cmd_out and data_out are zero.
- R2: The slave acknowledges an address byte equal to binary 1,0,0,1,1,strap[1],strap[0],0 (MSB first, last bit is the write bit). Acknowledge means that SDA reads low during the high phase of the ninth SCL clock.
- R3: Any other address byte, including one whose last bit is 1 (read), gets no acknowledge. After such a byte the slave acknowledges nothing and commits nothing until the next START.
- R4: The slave acknowledges the command byte. A command with bit 6 set expects two payload bytes. Any other command expects one.
- R5: Byte frame: after the payload byte is acknowledged, commit pulses, cmd_out holds the command and data_out equals {8'h00, payload}. SDA is released by the time commit is seen.
- R6: Word frame: the first payload byte goes to data_out[15:8] and the second to data_out[7:0]. Commit fires only after the second byte has been acknowledged.
- R7: Commit is high for exactly one clock, once per complete frame. cmd_out and data_out change only in the cycle commit is high.
- R8: A STOP or a repeated START before the final acknowledge throws away the partial frame. No commit follows, and the outputs keep their earlier values.
- R9: Bytes sent after the final payload byte of a frame get no acknowledge and cause no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| strap | input | 2 | Strap value for the two low address bits |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| cmd_out | output | 8 | Command byte of the last committed frame |
| data_out | output | 16 | Payload of the last committed frame |
| commit | output | 1 | One-cycle strobe when a frame completes |

## Verification
Each bus edge reaches the decode logic two synchronizer flops later and is detected one cycle after that. sda_pull therefore changes about four system clocks after the SCL fall that opens or closes an acknowledge slot. Commit follows the fall that ends the final acknowledge by the same amount. The bench holds every SCL phase for ten clocks. It reads the acknowledge in the middle of the ninth SCL high phase, and it checks commit counts and outputs several quarter-periods after STOP, well past the point where every result has settled. A monitor on the falling clock edge counts commit pulses and measures their width.

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter logic [4:0] DEV_ID   = 5'b10011,
  parameter int         WORD_BIT = 6,
  parameter int         SYNC     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [1:0]  strap,
  output logic        sda_pull,
  output logic [7:0]  cmd_out,
  output logic [15:0] data_out,
  output logic        commit
);
  typedef enum logic [2:0] {IDLE, RX, ACK_WAIT, ACK, HOLD} st_t;

  logic [SYNC:0] scl_p, sda_p;
  st_t           st;
  logic [2:0]    bit_cnt;
  logic [1:0]    phase;
  logic [7:0]    shreg, cmd_r, hi_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC-1:0], scl_in};
      sda_p <= {sda_p[SYNC-1:0], sda_in};
    end

  wire scl_s = scl_p[SYNC-1];
  wire scl_q = scl_p[SYNC];
  wire sda_s = sda_p[SYNC-1];
  wire sda_q = sda_p[SYNC];

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  wire [7:0] byte_now = {shreg[6:0], sda_s};
  wire addr_ok  = byte_now == {DEV_ID, strap, 1'b0};
  wire is_word  = cmd_r[WORD_BIT];
  wire last_byt = (phase == 2'd3) || (phase == 2'd2 && !is_word);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= IDLE;
      bit_cnt  <= '0;
      phase    <= '0;
      shreg    <= '0;
      cmd_r    <= '0;
      hi_r     <= '0;
      sda_pull <= 1'b0;
      commit   <= 1'b0;
      cmd_out  <= '0;
      data_out <= '0;
    end else begin
      commit <= 1'b0;
      if (start_c) begin
        st       <= RX;
        bit_cnt  <= '0;
        phase    <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          RX: if (scl_rise) begin
            shreg   <= byte_now;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              case (phase)
                2'd0:    st <= addr_ok ? ACK_WAIT : HOLD;
                2'd1:    begin cmd_r <= byte_now; st <= ACK_WAIT; end
                2'd2:    begin hi_r  <= byte_now; st <= ACK_WAIT; end
                default: st <= ACK_WAIT;
              endcase
            end
          end
          ACK_WAIT: if (scl_fall) begin
            sda_pull <= 1'b1;
            st       <= ACK;
          end
          ACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            if (last_byt) begin
              commit   <= 1'b1;
              cmd_out  <= cmd_r;
              data_out <= is_word ? {hi_r, shreg} : {8'h00, shreg};
              st       <= HOLD;
            end else begin
              phase   <= phase + 2'd1;
              bit_cnt <= '0;
              st      <= RX;
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_in,
  input logic        sda_pull,
  input logic [7:0]  cmd_out,
  input logic [15:0] data_out,
  input logic        commit
);
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) commit |=> !commit); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !commit |-> ($stable(cmd_out) && $stable(data_out))); // R7
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (commit && !cmd_out[6]) |-> data_out[15:8] == 8'h00); // R5
  AST_RELEASED_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) commit |-> !sda_pull); // R5
  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull) |-> !scl_in); // R2
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .cmd_out(cmd_out), .data_out(data_out), .commit(commit)
);

// File: tb/i2c_cmd_slave_tb.sv
module i2c_cmd_slave_tb;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_pull, commit;
  logic [7:0] cmd_out;
  logic [15:0] data_out;
  wire sda_line = sda_m & ~sda_pull;
  int checks = 0, bad = 0, commits = 0, cur_w = 0, max_w = 0;
  logic [7:0] exp_cmd = 8'h00;
  logic [15:0] exp_data = 16'h0000;

  always #10 clk = ~clk;

  i2c_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .strap(strap),
    .sda_pull(sda_pull), .cmd_out(cmd_out), .data_out(data_out), .commit(commit)
  );

  always @(negedge clk) begin
    if (commit) begin
      if (cur_w == 0) commits++;
      cur_w++;
      if (cur_w > max_w) max_w = cur_w;
    end else cur_w = 0;
  end

  // {strap, address, command, first payload, second payload}
  localparam logic [33:0] VEC [8] = '{
    {2'd0, 8'h98, 8'h01, 8'h05, 8'h00},
    {2'd3, 8'h9E, 8'h40, 8'hA5, 8'h3C},
    {2'd1, 8'h9A, 8'h80, 8'h3F, 8'h00},
    {2'd2, 8'h9C, 8'h7F, 8'h0F, 8'hF0},
    {2'd2, 8'h98, 8'h01, 8'h11, 8'h00},
    {2'd0, 8'h99, 8'h02, 8'h22, 8'h00},
    {2'd1, 8'h9A, 8'hC3, 8'hFF, 8'h00},
    {2'd0, 8'h18, 8'h04, 8'h33, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic q(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(3);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(2); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    bit ack;
    int c0;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0 && commit == 1'b0, "R1 reset drive", {sda_pull, commit}, 0);
    chk(cmd_out == 8'h00 && data_out == 16'h0000, "R1 reset outputs", {cmd_out, data_out}, 0);
    rst_n = 1'b1;
    q(2);

    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, c, h, l;
      bit match, word;
      {strap, a, c, h, l} = VEC[v];
      match = (a == {5'b10011, strap, 1'b0});
      word  = c[6];
      c0 = commits;
      q();
      bus_start();
      send(a, ack);
      chk(ack == match, match ? "R2 address ack" : "R3 address nack", ack, match);
      send(c, ack);
      chk(ack == match, "R4 command ack", ack, match);
      send(h, ack);
      chk(ack == match, "R4 first payload ack", ack, match);
      if (word) begin
        send(l, ack);
        chk(ack == match, "R6 second payload ack", ack, match);
      end
      bus_stop();
      if (match) begin
        exp_cmd  = c;
        exp_data = word ? {h, l} : {8'h00, h};
      end
      chk(commits - c0 == (match ? 1 : 0), match ? "R5 commit count" : "R3 no commit", commits - c0, match);
      chk(cmd_out == exp_cmd && data_out == exp_data, word ? "R6 word outputs" : "R5 byte outputs",
          {cmd_out, data_out}, {exp_cmd, exp_data});
    end

    // R8: STOP after the first payload byte of a word frame
    strap = 2'd1; c0 = commits;
    bus_start(); send(8'h9A, ack); send(8'h40, ack); send(8'h12, ack); bus_stop();
    chk(commits == c0, "R8 stop discards", commits - c0, 0);
    chk(cmd_out == exp_cmd && data_out == exp_data, "R8 outputs kept", {cmd_out, data_out}, {exp_cmd, exp_data});

    // R8: repeated START mid-frame, then a full byte frame
    c0 = commits;
    bus_start(); send(8'h9A, ack); send(8'h08, ack);
    bus_start(); send(8'h9A, ack); send(8'h20, ack); send(8'h77, ack);
    chk(ack == 1'b1, "R8 restart frame ack", ack, 1);
    bus_stop();
    chk(commits == c0 + 1, "R8 one commit after restart", commits - c0, 1);
    chk(cmd_out == 8'h20 && data_out == 16'h0077, "R8 restart outputs", {cmd_out, data_out}, 24'h200077);
    exp_cmd = 8'h20; exp_data = 16'h0077;

    // R9: extra byte after the final payload byte
    c0 = commits;
    bus_start(); send(8'h9A, ack); send(8'h02, ack); send(8'h5A, ack); send(8'hC6, ack);
    chk(ack == 1'b0, "R9 extra byte nack", ack, 0);
    bus_stop();
    chk(commits == c0 + 1, "R9 single commit", commits - c0, 1);
    chk(data_out == 16'h005A, "R9 extra byte ignored", data_out, 16'h005A);

    chk(max_w == 1, "R7 commit width", max_w, 1);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule